// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a single-clock request port to an external asynchronous static RAM of 128K bytes. A request carries a 17-bit address, a direction and, for writes, one data byte. The controller latches the whole request and drives the memory's two chip selects (one active-low, one active-high), its active-low write strobe and its active-low output enable. It drives the memory data bus through a separate output byte and a drive-enable. Read data comes back with a one-cycle valid pulse. `ready` tells the requester when a new request can be taken.

Each phase lasts a whole number of clock cycles. The count is worked out at elaboration from minimum times given in nanoseconds and from the clock period. Each count is the time divided by the period, rounded up, and never less than one cycle. The write pulse must cover the strobe width, the data setup time and the address-valid time. With the hold cycle that follows it, the pulse must also cover the full write cycle. The read window must cover address access, output-enable access and read cycle time. A write that follows a read first waits out the memory's output-release time. Only then does the controller turn on its own drivers.

With the default parameters (5 ns clock), the write pulse lasts 2 cycles. It is followed by 1 hold cycle. The read window is 2 cycles, and the turnaround wait is 2 cycles.

Top module: `sram_async_ctl`

## Requirements
- R1: After reset, and at any time the controller is idle, the pins are held as follows: `ready`=1, `sram_ce_n`=1, `sram_ce`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0 and `rd_valid`=0.
- R2: `sram_we_n` is low only while all of these hold: `sram_ce_n`=0, `sram_ce`=1, `sram_oe_n`=1 and `sram_dq_oe`=1.
- R3: A write holds `sram_we_n` low for exactly N_WP consecutive cycles (2 at defaults). One hold cycle follows, with `sram_we_n`=1, the chip still selected, the bus still driven and the address unchanged. The written byte is the one presented with the request.
- R4: A read holds `sram_oe_n`=0, the chip selected, `sram_we_n`=1 and `sram_dq_oe`=0 for N_RD cycles (2 at defaults). The byte on `sram_dq_in` is captured on the edge that ends this window. `rd_valid` is then high for exactly one cycle, with the captured byte on `rd_data`.
- R5: When a write directly follows a read, `sram_dq_oe` stays low for at least N_TURN full cycles (2 at defaults) after `sram_oe_n` returns high.
- R6: `ready` falls on the edge that accepts a request. It returns high after N_RD further edges for a read and after N_WP+1 further edges for a write. A write that needs the turnaround wait takes N_TURN edges more.
- R7: A request is taken only when `req_valid`=1 while `ready`=1. Changes on the request inputs during an access have no effect on `sram_addr`, on the written byte, or on the number of accesses.
- R8: `sram_addr` stays stable for as long as the chip is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Idle; a request is accepted this cycle |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 8 | Captured read byte |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Active-low chip select |
| sram_ce | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Byte driven onto the memory bus |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | 8 | Byte read from the memory bus |

## Verification
Inputs change on falling edges and outputs are sampled on falling edges. After a request is accepted, the bench counts falling edges until `ready` returns. It expects 2 for a read, 3 for a write and 5 for a write that follows a read. On the falling edge where a read's `ready` returns, `rd_valid` must be high with the expected byte, and it must be low one edge later. Monitors run on every falling edge: they measure the width of each write strobe, check the legal combinations of strobe levels, and count the gap between output enable and driver enable, so every check lands on the cycle in which its result is due.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_WRITE = 3'd2,
    ST_WHOLD = 3'd3,
    ST_READ  = 3'd4
  } ctl_state_t;

  // cycles needed to cover a time, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_state_t st_nxt,
  output logic       ce_n,
  output logic       ce,
  output logic       we_n,
  output logic       oe_n,
  output logic       dq_oe
);

  logic sel_d, we_d, oe_d, drv_d;

  always_comb begin
    sel_d = (st_nxt == ST_WRITE) || (st_nxt == ST_WHOLD) || (st_nxt == ST_READ);
    we_d  = (st_nxt == ST_WRITE);
    oe_d  = (st_nxt == ST_READ);
    drv_d = (st_nxt == ST_WRITE) || (st_nxt == ST_WHOLD);
  end

  // strobes come straight from flops so they cannot glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      ce    <= 1'b0;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= !sel_d;
      ce    <= sel_d;
      we_n  <= !we_d;
      oe_n  <= !oe_d;
      dq_oe <= drv_d;
    end
  end

  // R2: write strobe only with the chip selected, outputs off, bus driven
  a_r2_write_select: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && ce && oe_n && dq_oe));

  // R4: output enable never overlaps a write or our own drive
  a_r4_read_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !dq_oe && !ce_n && ce));

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned T_WP_NS   = 8,
  parameter int unsigned T_DS_NS   = 7,
  parameter int unsigned T_AW_NS   = 10,
  parameter int unsigned T_WC_NS   = 10,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_OE_NS   = 6,
  parameter int unsigned T_RC_NS   = 10,
  parameter int unsigned T_OEZ_NS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  // write pulse covers strobe width, data setup, address valid, and with the
  // hold cycle the whole write cycle
  localparam int unsigned N_WP = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                                      max2(ns_to_cyc(T_AW_NS, CLK_NS), max2(ns_to_cyc(T_WC_NS, CLK_NS) - 1, 1)));
  localparam int unsigned N_RD = max2(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                      ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned N_TURN = ns_to_cyc(T_OEZ_NS, CLK_NS);
  localparam int unsigned N_MAX  = max2(max2(N_WP, N_RD), N_TURN);
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);
  localparam int unsigned GAP_W  = $clog2(N_TURN + 2);

  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(N_TURN - 1);

  ctl_state_t        st_q, st_d;
  logic              t_load, t_done;
  logic [CNT_W-1:0]  t_val;
  logic              accept;
  logic              rd_recent_q, rd_recent_d;
  logic              rd_end;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign rd_end = (st_q == ST_READ) && t_done;

  // next state
  always_comb begin
    st_d        = st_q;
    t_load      = 1'b0;
    t_val       = LD_WP;
    rd_recent_d = rd_recent_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        t_load = 1'b1;
        if (!req_write) begin
          st_d  = ST_READ;
          t_val = LD_RD;
        end else if (rd_recent_q) begin
          st_d  = ST_TURN;
          t_val = LD_TURN;
        end else begin
          st_d        = ST_WRITE;
          t_val       = LD_WP;
          rd_recent_d = 1'b0;
        end
      end
      ST_TURN: if (t_done) begin
        st_d        = ST_WRITE;
        t_load      = 1'b1;
        t_val       = LD_WP;
        rd_recent_d = 1'b0;
      end
      ST_WRITE: if (t_done) st_d = ST_WHOLD;
      ST_WHOLD: st_d = ST_IDLE;
      ST_READ: if (t_done) begin
        st_d        = ST_IDLE;
        rd_recent_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rd_recent_q <= 1'b0;
    end else begin
      st_q        <= st_d;
      rd_recent_q <= rd_recent_d;
    end
  end

  // request latch, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read capture on the edge closing the access window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_end) rd_data <= sram_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_end;
  end

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  sram_pin_drv i_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_nxt (st_d),
    .ce_n   (sram_ce_n),
    .ce     (sram_ce),
    .we_n   (sram_we_n),
    .oe_n   (sram_oe_n),
    .dq_oe  (sram_dq_oe)
  );

  assign ready       = (st_q == ST_IDLE);
  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;

  // ---------------- checks ----------------
  // cycles since output enable was last low, saturating
  logic [GAP_W-1:0] oe_gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         oe_gap_q <= GAP_W'(N_TURN + 1);
    else if (!sram_oe_n)                oe_gap_q <= '0;
    else if (oe_gap_q != GAP_W'(N_TURN + 1)) oe_gap_q <= oe_gap_q + 1'b1;
  end

  // R1: idle means deselected and quiet
  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe));

  // R4: read valid is a single-cycle pulse
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R5: own drivers wait out the memory's output release
  a_r5_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_gap_q >= GAP_W'(N_TURN)));

  // R6: never ready while the chip is selected
  a_r6_busy_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !ready);

  // R8: address holds while selected
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

// File: tb/test_sram_async_ctl.sv
module test_sram_async_ctl;

  localparam int N_WP   = 2;
  localparam int N_RD   = 2;
  localparam int N_TURN = 2;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ready, rd_valid;
  logic [7:0]  rd_data;
  logic [16:0] sram_addr;
  logic        sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out, sram_dq_in;

  int checks = 0;
  int failures = 0;

  sram_async_ctl i_sram_async_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce(sram_ce),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // small memory model keyed by the low address byte
  logic [7:0] mem [0:255];
  assign sram_dq_in = (!sram_ce_n && sram_ce && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : 8'hEE;

  // pin monitors
  int cyc = 0;
  int last_oe_low = -100;
  int we_run = 0;
  int we_width = 0;
  int bad_combo = 0;
  int bad_gap = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!sram_we_n) begin
        if (sram_ce_n || !sram_ce || !sram_oe_n || !sram_dq_oe) bad_combo++;
        mem[sram_addr[7:0]] = sram_dq_out;
        we_run++;
      end else if (we_run != 0) begin
        we_width = we_run;
        we_run = 0;
      end
      if (!sram_oe_n) begin
        if (!sram_we_n || sram_dq_oe) bad_combo++;
        last_oe_low = cyc;
      end
      if (sram_dq_oe && (cyc - last_oe_low) <= N_TURN) bad_gap++;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // issue one request; returns edges until ready comes back
  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d, output int edges);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    edges = 0;
    while (!ready && edges < 50) begin
      @(negedge clk);
      edges++;
    end
  endtask

  // {write, address, data or expected byte}
  localparam logic [25:0] VEC [0:7] = '{
    {1'b1, 17'h00012, 8'hA5},
    {1'b1, 17'h1FF34, 8'h3C},
    {1'b0, 17'h00012, 8'hA5},
    {1'b1, 17'h00056, 8'hFF},
    {1'b0, 17'h1FF34, 8'h3C},
    {1'b0, 17'h00056, 8'hFF},
    {1'b1, 17'h00078, 8'h00},
    {1'b0, 17'h00078, 8'h00}
  };

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int edges;
    bit prev_rd;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ready && sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe && !rd_valid,
        "R1 reset idle pins", {ready, sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe, rd_valid}, 7'b1101100);

    prev_rd = 1'b0;
    for (int v = 0; v < 8; v++) begin
      issue(VEC[v][25], VEC[v][24:8], VEC[v][7:0], edges);
      if (VEC[v][25]) begin
        chk(edges == N_WP + 1 + (prev_rd ? N_TURN : 0), "R6 write ready return", edges,
            N_WP + 1 + (prev_rd ? N_TURN : 0));
        chk(we_width == N_WP, "R3 write strobe width", we_width, N_WP);
        chk(mem[VEC[v][15:8]] == VEC[v][7:0], "R3 written byte", mem[VEC[v][15:8]], VEC[v][7:0]);
        prev_rd = 1'b0;
      end else begin
        chk(edges == N_RD, "R6 read ready return", edges, N_RD);
        chk(rd_valid && rd_data == VEC[v][7:0], "R4 read data valid", rd_data, VEC[v][7:0]);
        @(negedge clk);
        chk(!rd_valid, "R4 valid single cycle", rd_valid, 0);
        prev_rd = 1'b1;
      end
    end

    // R7: request inputs changed during a write are ignored
    issue(1'b0, 17'h00012, 8'h00, edges); // read first, so next write turns around
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00099; req_wdata = 8'h5A;
    @(negedge clk);
    req_write = 1'b0; req_addr = 17'h0AAAA; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 1'b0;
    edges = 0;
    while (!ready && edges < 50) begin
      if (!sram_ce_n) chk(sram_addr == 17'h00099, "R8 address held", sram_addr, 17'h00099);
      @(negedge clk);
      edges++;
    end
    chk(edges == N_WP + N_TURN, "R5 turnaround delays write", edges + 1, N_WP + 1 + N_TURN);
    chk(mem[8'h99] == 8'h5A, "R7 latched write byte", mem[8'h99], 8'h5A);
    chk(mem[8'hAA] == 8'h00, "R7 no write at changed address", mem[8'hAA], 8'h00);
    repeat (3) @(negedge clk);
    chk(ready && sram_ce_n && !sram_ce, "R7 no extra access", sram_ce_n, 1);

    issue(1'b0, 17'h00099, 8'h00, edges);
    chk(rd_valid && rd_data == 8'h5A, "R7 readback of latched byte", rd_data, 8'h5A);

    chk(bad_combo == 0, "R2 strobe combination violations", bad_combo, 0);
    chk(bad_gap == 0, "R5 driver enable too soon after output enable", bad_gap, 0);
    @(negedge clk);
    chk(ready && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 idle after traffic", ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule